// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

A 32-bit register-mapped seconds counter for a chip's always-on domain. A one-cycle pulse on `tick_i`, produced elsewhere from a prescaler, advances the count once per second. Software sets the time through a load register. The load does not take effect when it is written. It is held pending and replaces the increment on the next enabled tick, so the visible count can only change on a second boundary.

A match register holds an alarm time. When an enabled tick moves the counter onto the match value, a raw alarm flag is set, provided the alarm enable bit is set. A separate mask bit gates the flag onto the masked status register and onto the level interrupt `irq_o`. Reading the end-of-interrupt word clears the flag. The control register also selects whether the count wraps to zero or saturates at its top value.

The bus is a single strobe with a write flag and a byte address. Only word-aligned offsets decode. Read data is combinational from the address. Writes to read-only words have no effect.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset, the following all read 0 and `irq_o` is 0: counter (0x00), match (0x04), load (0x08), control (0x0C), masked status (0x10) and raw status (0x14).
- R2: When control bit 2 (count enable) is 1, the counter increases by 1 in the cycle after each `tick_i` pulse. It does not change in cycles without a tick.
- R3: When count enable is 0, ticks leave the counter unchanged and do not consume a pending load.
- R4: A write to 0x08 reads back at once. The counter keeps counting normally until the next enabled tick, where it takes the written value instead of incrementing.
- R5: On an enabled tick at the all-ones value, the counter becomes 0 if control bit 3 (wrap enable) is 1. If wrap enable is 0, the counter stays at all-ones.
- R6: Raw status bit 0 at 0x14 is set in the cycle after an enabled tick whose new counter value equals the match register (0x04), but only if control bit 0 (alarm enable) was 1. Otherwise the bit is unchanged.
- R7: Masked status bit 0 at 0x10 and `irq_o` equal the raw flag when control bit 1 (mask) is 0, and are 0 when mask is 1.
- R8: A read of 0x18 returns 0 and clears the raw flag at the next edge. If a new match occurs in the same cycle, the flag stays set.
- R9: Offset 0x1C reads the `VERSION` parameter. Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing. Addresses with bits [1:0] not zero read 0 and ignore writes.
- R10: Control bits [3:0] read back as written, and bits [31:4] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Level alarm interrupt after masking |

## Verification
The bench builds the block with the default 32-bit count and address width, and overrides `VERSION` with a distinctive pattern so that a wrong constant is visible. Because loads apply on a tick, the bench can move the counter straight to the top of its range. This makes saturation and wrap reachable in a few cycles rather than four billion ticks. With the full width, all eight words and the misaligned addresses can also be swept.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  localparam int OFF_COUNT  = 0;
  localparam int OFF_MATCH  = 1;
  localparam int OFF_LOAD   = 2;
  localparam int OFF_CTRL   = 3;
  localparam int OFF_MSTAT  = 4;
  localparam int OFF_RSTAT  = 5;
  localparam int OFF_EOI    = 6;
  localparam int OFF_VER    = 7;
  localparam int CTRL_W     = 4;

  // bit 3 wrap, bit 2 count enable, bit 1 mask, bit 0 alarm enable
  typedef struct packed {
    logic wrap_en;
    logic cnt_en;
    logic irq_mask;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/sec_alarm_regs.sv
module sec_alarm_regs
  import sec_alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_match_i,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  match_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      match_o <= '0;
      load_o  <= '0;
      pend_o  <= 1'b0;
    end else begin
      if (wr_ctrl_i)  ctrl_o  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_match_i) match_o <= wdata_i[CNT_W-1:0];
      if (wr_load_i)  load_o  <= wdata_i[CNT_W-1:0];
      // a write in the applying cycle stays pending for the next tick
      if (wr_load_i)   pend_o <= 1'b1;
      else if (step_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sec_alarm_count.sv
module sec_alarm_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             wrap_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_comb begin
    if (pend_i)           cnt_nxt_o = load_i;
    else if (cnt_o == TOP) cnt_nxt_o = wrap_en_i ? '0 : TOP;
    else                  cnt_nxt_o = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_nxt_o;
  end
endmodule

// File: rtl/sec_alarm_irq.sv
module sec_alarm_irq #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             irq_en_i,
  input  logic             irq_mask_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             eoi_i,
  output logic             raw_o,
  output logic             masked_o
);
  logic hit;
  assign hit = step_i && irq_en_i && (cnt_nxt_i == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_o <= 1'b0;
    else if (hit)    raw_o <= 1'b1;
    else if (eoi_i)  raw_o <= 1'b0;
  end

  assign masked_o = raw_o & ~irq_mask_i;
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sec_alarm_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned, wr, rd, step;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] match_q, load_q, cnt_q, cnt_nxt;
  logic             pend_q, raw_q, masked;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;
  assign step    = tick_i & ctrl_q.cnt_en;

  sec_alarm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr && idx == IDX_W'(OFF_CTRL)),
    .wr_match_i (wr && idx == IDX_W'(OFF_MATCH)),
    .wr_load_i  (wr && idx == IDX_W'(OFF_LOAD)),
    .wdata_i    (wdata_i),
    .step_i     (step),
    .ctrl_o     (ctrl_q),
    .match_o    (match_q),
    .load_o     (load_q),
    .pend_o     (pend_q)
  );

  sec_alarm_count #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .pend_i    (pend_q),
    .load_i    (load_q),
    .wrap_en_i (ctrl_q.wrap_en),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  sec_alarm_irq #(.CNT_W(CNT_W)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .irq_en_i   (ctrl_q.irq_en),
    .irq_mask_i (ctrl_q.irq_mask),
    .cnt_nxt_i  (cnt_nxt),
    .match_i    (match_q),
    .eoi_i      (rd && idx == IDX_W'(OFF_EOI)),
    .raw_o      (raw_q),
    .masked_o   (masked)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (int'(idx))
        OFF_COUNT: rdata_o = DATA_W'(cnt_q);
        OFF_MATCH: rdata_o = DATA_W'(match_q);
        OFF_LOAD:  rdata_o = DATA_W'(load_q);
        OFF_CTRL:  rdata_o = DATA_W'(ctrl_q);
        OFF_MSTAT: rdata_o = DATA_W'(masked);
        OFF_RSTAT: rdata_o = DATA_W'(raw_q);
        OFF_VER:   rdata_o = DATA_W'(VERSION);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = masked;
endmodule

// File: rtl/sec_alarm_chk.sv
module sec_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cnt_en,
  input logic             irq_en,
  input logic             irq_mask,
  input logic             eoi_rd,
  input logic             raw,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] match
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt));
  p_disabled_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en |=> $stable(cnt));
  p_hit_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(raw) && $stable(match)) |-> (cnt == match));
  p_hit_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw) |-> $past(irq_en));
  p_mask_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw && !irq_mask));
  p_eoi_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_rd && !tick_i) |=> !raw);
endmodule

bind sec_alarm_timer sec_alarm_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .cnt_en   (ctrl_q.cnt_en),
  .irq_en   (ctrl_q.irq_en),
  .irq_mask (ctrl_q.irq_mask),
  .eoi_rd   (rd && idx == IDX_W'(sec_alarm_pkg::OFF_EOI)),
  .raw      (raw_q),
  .irq_o    (irq_o),
  .cnt      (cnt_q),
  .match    (match_q)
);

// File: tb/test_sec_alarm_timer.sv
module test_sec_alarm_timer;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0, miscompares = 0;

  // reference state
  logic [31:0] m_cnt = 0, m_match = 0, m_load = 0;
  logic [3:0]  m_ctrl = 0;
  logic        m_pend = 0, m_raw = 0;

  always #10 clk = ~clk;

  sec_alarm_timer #(.VERSION(VER)) i_sec_alarm_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt;
      3'd1: return m_match;
      3'd2: return m_load;
      3'd3: return {28'h0, m_ctrl};
      3'd4: return {31'h0, m_raw & ~m_ctrl[1]};
      3'd5: return {31'h0, m_raw};
      3'd7: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_step(input logic r, input logic w, input logic [4:0] a,
                        input logic [31:0] d, input logic t);
    logic ev, hit, ok;
    logic [31:0] nxt;
    ok  = r && (a[1:0] == 2'b00);
    ev  = t && m_ctrl[2];
    if (m_pend) nxt = m_load;
    else if (m_cnt == 32'hFFFF_FFFF) nxt = m_ctrl[3] ? 32'h0 : m_cnt;
    else nxt = m_cnt + 1;
    hit = ev && m_ctrl[0] && (nxt == m_match);
    if (hit) m_raw = 1'b1;
    else if (ok && !w && a[4:2] == 3'd6) m_raw = 1'b0;
    if (ev) begin m_cnt = nxt; m_pend = 1'b0; end
    if (ok && w) begin
      case (a[4:2])
        3'd1: m_match = d;
        3'd2: begin m_load = d; m_pend = 1'b1; end
        3'd3: m_ctrl = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [4:0] a,
                     input logic [31:0] d, input logic t, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; tick = t;
    #1;
    exp = m_read(a);
    vectors++;
    if (rdata !== exp) begin
      miscompares++;
      $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, a, rdata, exp);
    end
    vectors++;
    if (irq !== (m_raw & ~m_ctrl[1])) begin
      miscompares++;
      $display("FAIL R7 (%s) irq actual=%b expected=%b", tag, irq, m_raw & ~m_ctrl[1]);
    end
    @(posedge clk);
    m_step(r, w, a, d, t);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, tag);
  endtask
  task automatic rd_reg(input logic [4:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
  endtask
  task automatic tk(input logic [4:0] a, input string tag);
    cyc(1'b0, 1'b0, a, 32'h0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) rd_reg(5'(i * 4), "R1");
    // R10 control readback, upper bits zero
    wr_reg(5'h0C, 32'hFFFF_FFF0, "R10");
    rd_reg(5'h0C, "R10");
    wr_reg(5'h0C, 32'h0000_0004, "R10");
    rd_reg(5'h0C, "R10");
    // R2 counting with gaps
    for (int i = 0; i < 6; i++) begin
      tk(5'h00, "R2");
      for (int j = 0; j < i; j++) rd_reg(5'h00, "R2");
    end
    // R4 load applies on next tick only
    wr_reg(5'h08, 32'd100, "R4");
    rd_reg(5'h08, "R4");
    rd_reg(5'h00, "R4");
    tk(5'h00, "R4");
    rd_reg(5'h00, "R4");
    tk(5'h00, "R4");
    rd_reg(5'h00, "R4");
    // R3 disabled: hold, pending kept
    wr_reg(5'h0C, 32'h0, "R3");
    wr_reg(5'h08, 32'd5, "R3");
    tk(5'h00, "R3"); tk(5'h00, "R3");
    rd_reg(5'h00, "R3");
    wr_reg(5'h0C, 32'h4, "R3");
    tk(5'h00, "R3");
    rd_reg(5'h00, "R3");
    // R5 saturate then wrap
    wr_reg(5'h08, 32'hFFFF_FFFE, "R5");
    tk(5'h00, "R5"); tk(5'h00, "R5"); tk(5'h00, "R5"); tk(5'h00, "R5");
    rd_reg(5'h00, "R5");
    wr_reg(5'h0C, 32'hC, "R5");
    tk(5'h00, "R5");
    rd_reg(5'h00, "R5");
    tk(5'h00, "R5");
    rd_reg(5'h00, "R5");
    // R6 alarm with enable
    wr_reg(5'h04, 32'd4, "R6");
    wr_reg(5'h0C, 32'h5, "R6");
    for (int i = 0; i < 4; i++) begin tk(5'h14, "R6"); rd_reg(5'h14, "R6"); end
    rd_reg(5'h10, "R7");
    // R7 mask gating
    wr_reg(5'h0C, 32'h7, "R7");
    rd_reg(5'h10, "R7");
    rd_reg(5'h14, "R7");
    wr_reg(5'h0C, 32'h5, "R7");
    rd_reg(5'h10, "R7");
    // R8 EOI clears, read data zero
    rd_reg(5'h18, "R8");
    rd_reg(5'h14, "R8");
    // R6 no set when alarm enable is 0
    wr_reg(5'h0C, 32'h4, "R6");
    wr_reg(5'h08, 32'd9, "R6");
    wr_reg(5'h04, 32'd9, "R6");
    tk(5'h14, "R6");
    rd_reg(5'h14, "R6");
    rd_reg(5'h00, "R6");
    // R8 match in the EOI cycle wins
    wr_reg(5'h0C, 32'h5, "R8");
    wr_reg(5'h04, 32'd10, "R8");
    tk(5'h14, "R8");
    wr_reg(5'h04, 32'd11, "R8");
    cyc(1'b1, 1'b0, 5'h18, 32'h0, 1'b1, "R8");
    rd_reg(5'h14, "R8");
    rd_reg(5'h18, "R8");
    rd_reg(5'h14, "R8");
    // R9 read-only words and misaligned accesses ignore writes
    wr_reg(5'h00, 32'h1234_5678, "R9");
    wr_reg(5'h10, 32'hFFFF_FFFF, "R9");
    wr_reg(5'h14, 32'hFFFF_FFFF, "R9");
    wr_reg(5'h1C, 32'h0, "R9");
    wr_reg(5'h05, 32'hDEAD_BEEF, "R9");
    wr_reg(5'h0E, 32'h0, "R9");
    for (int i = 0; i < 8; i++) rd_reg(5'(i * 4), "R9");
    rd_reg(5'h1D, "R9");
    rd_reg(5'h06, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule